// File: doc/BRIEF.md
# Page-Mode Asynchronous DRAM Controller

This block sequences a multiplexed-address asynchronous DRAM from a synchronous request port. A requester presents one word read or write at a time through a valid/ready handshake. The controller splits the request address into a row half and a column half. Both halves go out on one shared address bus. The row half is placed there when the row strobe falls, and the column half when the column strobe falls. All four DRAM control strobes are active low, and every timing limit is counted in clock cycles set by parameters.

After an access the row is left open. A following request to the same row is a page hit: the row strobe stays low and only the column strobe cycles. A request to a different row raises the row strobe and waits out the rest of the row cycle time before it opens the new row. Read data is sampled into a register when the column-to-data count runs out, and a one-cycle read-valid pulse announces it. The data bus is split into an output, an output enable and an input. The output enable is raised only for writes.

Top module: `pgdram_ctrl`

## Requirements
- R1: In reset and in the first cycle after it, `dram_ras_n`, `dram_cas_n`, `dram_we_n` and `dram_oe_n` are all 1, `dram_dq_oe` is 0, `rd_valid` is 0 and `req_ready` is 1.
- R2: The row is the upper A_W bits of `req_addr` and the column is the lower A_W bits. `dram_addr` carries the row in the first cycle `dram_ras_n` is low, and the column in the first cycle `dram_cas_n` is low.
- R3: When a row is newly opened, `dram_cas_n` falls exactly T_RAC-T_CAC cycles after `dram_ras_n` falls. For a read, `rd_data` takes the value on `dram_dq_i` at the end of the T_CAC-th cycle that `dram_cas_n` is low. `rd_valid` is high for exactly one cycle, T_CAC cycles after the column strobe falls.
- R4: A write is an early write. `dram_we_n` is 0 and `dram_dq_oe` is 1 with `dram_dq_o` equal to the request data in the cycle before `dram_cas_n` falls and in the cycle it falls.
- R5: `dram_we_n` and `dram_oe_n` are never 0 together, and `dram_oe_n` is 1 in every cycle where `dram_dq_oe` is 1.
- R6: For a read, `dram_oe_n` is 0, `dram_we_n` is 1 and `dram_dq_oe` is 0 in the first cycle `dram_cas_n` is low.
- R7: A request to the row last opened causes no fall of `dram_ras_n`. Any two falls of `dram_cas_n` are at least T_PC cycles apart.
- R8: A request to any other row causes exactly one fall of `dram_ras_n`. Any two falls of `dram_ras_n` are at least T_RC cycles apart.
- R9: `dram_cas_n` falls only while `dram_ras_n` is 0.
- R10: A request is taken in a cycle with `req_valid` and `req_ready` both high. `req_ready` is 0 in the cycle after a request is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 2*A_W | Word address, row in upper half, column in lower half |
| req_wdata | input | DATA_W | Write data |
| rd_valid | output | 1 | One-cycle pulse: rd_data holds read result |
| rd_data | output | DATA_W | Captured read data |
| dram_addr | output | A_W | Shared row/column address bus |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_dq_o | output | DATA_W | Data driven to the DRAM |
| dram_dq_oe | output | 1 | Drive enable for dram_dq_o |
| dram_dq_i | input | DATA_W | Data returned by the DRAM |

## Verification
The hardest case to reach is the row-cycle gate after a row miss. The miss must arrive so soon after the row opened that the minimum page interval has passed but the row cycle time has not. Only then does the controller have to sit with the row strobe high and count the remainder. The bench reaches it by sending back-to-back requests with no idle gap that alternate between rows, and by drawing random traffic from only four rows, which gives a dense mix of hits and close misses. A DRAM model in the bench returns inverted junk until both the row and column access times have elapsed, so capturing the data one cycle early shows up as a data mismatch.

// File: rtl/pgdram_pkg.sv
`timescale 1ns/1ps
package pgdram_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ROW,
        ST_CSET,
        ST_COL,
        ST_OPEN,
        ST_PRE
    } seq_state_e;
endpackage

// File: rtl/pgdram_addr_split.sv
`timescale 1ns/1ps
module pgdram_addr_split #(
    parameter int A_W = 10
) (
    input  logic [2*A_W-1:0] req_addr,
    input  logic [A_W-1:0]   open_row,
    output logic [A_W-1:0]   row,
    output logic [A_W-1:0]   col,
    output logic             hit
);
    assign row = req_addr[2*A_W-1:A_W];
    assign col = req_addr[A_W-1:0];
    assign hit = (row == open_row);
endmodule

// File: rtl/pgdram_span_cnt.sv
`timescale 1ns/1ps
// Counts cycles since the last restart, saturating at LIMIT.
module pgdram_span_cnt #(
    parameter int LIMIT = 22,
    parameter int W     = $clog2(LIMIT + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         restart,
    output logic [W-1:0] count
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (restart)
            cnt_d = W'(1);
        else if (cnt_q < W'(LIMIT))
            cnt_d = cnt_q + W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= W'(LIMIT);
        else        cnt_q <= cnt_d;
    end

    assign count = cnt_q;

    always_ff @(posedge clk) begin
        if (rst_n) begin
            span_bound_chk: assert (cnt_q <= W'(LIMIT) && cnt_q != '0)
                else $error("span counter out of range");
        end
    end
endmodule

// File: rtl/pgdram_seq.sv
`timescale 1ns/1ps
module pgdram_seq
    import pgdram_pkg::*;
#(
    parameter int A_W    = 10,
    parameter int DATA_W = 16,
    parameter int T_RCD  = 9,
    parameter int T_CAC  = 3,
    parameter int T_RC   = 22,
    parameter int T_PC   = 7,
    parameter int RC_W   = 5,
    parameter int PC_W   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_we,
    input  logic [A_W-1:0]    req_row,
    input  logic [A_W-1:0]    req_col,
    input  logic              req_hit,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [RC_W-1:0]   rc_cnt,
    input  logic [PC_W-1:0]   pc_cnt,
    output logic              ras_fall,
    output logic              cas_fall,
    output logic [A_W-1:0]    open_row,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic [A_W-1:0]    dram_addr,
    output logic              dram_ras_n,
    output logic              dram_cas_n,
    output logic              dram_we_n,
    output logic              dram_oe_n,
    output logic [DATA_W-1:0] dram_dq_o,
    output logic              dram_dq_oe,
    input  logic [DATA_W-1:0] dram_dq_i
);
    localparam int CNT_MAX = (T_RCD > T_CAC) ? T_RCD : T_CAC;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);

    typedef struct packed {
        seq_state_e        state;
        logic [CNT_W-1:0]  cnt;
        logic              ras_n;
        logic              cas_n;
        logic              we_n;
        logic              oe_n;
        logic              dq_oe;
        logic [A_W-1:0]    addr;
        logic [DATA_W-1:0] dq_o;
        logic              we;
        logic [A_W-1:0]    row;
        logic [A_W-1:0]    col;
        logic [A_W-1:0]    open_row;
        logic              rd_valid;
        logic [DATA_W-1:0] rd_data;
    } seq_reg_t;

    seq_reg_t d, q;
    logic     take;
    logic     col_start;

    always_comb begin
        d         = q;
        d.rd_valid = 1'b0;
        ras_fall  = 1'b0;
        cas_fall  = 1'b0;
        req_ready = 1'b0;
        take      = 1'b0;
        col_start = 1'b0;

        unique case (q.state)
            ST_IDLE: begin
                req_ready = (rc_cnt >= RC_W'(T_RC));
                take      = req_valid && req_ready;
                if (take) begin
                    d.state    = ST_ROW;
                    d.ras_n    = 1'b0;
                    ras_fall   = 1'b1;
                    d.addr     = req_row;
                    d.open_row = req_row;
                    d.we_n     = !req_we;
                    d.dq_oe    = req_we;
                    d.cnt      = CNT_W'(1);
                end
            end
            ST_ROW: begin
                if (q.cnt == CNT_W'(T_RCD)) col_start = 1'b1;
                else d.cnt = q.cnt + CNT_W'(1);
            end
            ST_CSET: col_start = 1'b1;
            ST_COL: begin
                if (q.cnt == CNT_W'(T_CAC)) begin
                    if (!q.we) begin
                        d.rd_data  = dram_dq_i;
                        d.rd_valid = 1'b1;
                    end
                    d.state = ST_OPEN;
                    d.cas_n = 1'b1;
                    d.we_n  = 1'b1;
                    d.oe_n  = 1'b1;
                    d.dq_oe = 1'b0;
                end else begin
                    d.cnt = q.cnt + CNT_W'(1);
                end
            end
            ST_OPEN: begin
                req_ready = (pc_cnt >= PC_W'(T_PC - 1));
                take      = req_valid && req_ready;
                if (take && req_hit) begin
                    d.state = ST_CSET;
                    d.addr  = req_col;
                    d.we_n  = !req_we;
                    d.dq_oe = req_we;
                end else if (take) begin
                    d.state = ST_PRE;
                    d.ras_n = 1'b1;
                end
            end
            ST_PRE: begin
                if (rc_cnt >= RC_W'(T_RC)) begin
                    d.state    = ST_ROW;
                    d.ras_n    = 1'b0;
                    ras_fall   = 1'b1;
                    d.addr     = q.row;
                    d.open_row = q.row;
                    d.we_n     = !q.we;
                    d.dq_oe    = q.we;
                    d.cnt      = CNT_W'(1);
                end
            end
            default: d.state = ST_IDLE;
        endcase

        if (take) begin
            d.we   = req_we;
            d.row  = req_row;
            d.col  = req_col;
            d.dq_o = req_wdata;
        end

        if (col_start) begin
            d.state  = ST_COL;
            d.cas_n  = 1'b0;
            cas_fall = 1'b1;
            d.addr   = q.col;
            d.oe_n   = q.we;
            d.cnt    = CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q          <= '0;
            q.state    <= ST_IDLE;
            q.ras_n    <= 1'b1;
            q.cas_n    <= 1'b1;
            q.we_n     <= 1'b1;
            q.oe_n     <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign open_row   = q.open_row;
    assign rd_valid   = q.rd_valid;
    assign rd_data    = q.rd_data;
    assign dram_addr  = q.addr;
    assign dram_ras_n = q.ras_n;
    assign dram_cas_n = q.cas_n;
    assign dram_we_n  = q.we_n;
    assign dram_oe_n  = q.oe_n;
    assign dram_dq_o  = q.dq_o;
    assign dram_dq_oe = q.dq_oe;

    // R5
    strobe_conflict_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!q.we_n && !q.oe_n));
    // R5
    drive_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.dq_oe |-> q.oe_n);
    // R9
    cas_in_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(q.cas_n) |-> !q.ras_n);
    // R8
    row_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(q.ras_n) |-> ($past(rc_cnt) >= RC_W'(T_RC)));
    // R7
    page_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(q.cas_n) |-> ($past(pc_cnt) >= PC_W'(T_PC)));
    // R4
    early_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(q.cas_n) && !q.we_n) |-> ($past(!q.we_n) && $past(q.dq_oe)));
    // R3
    rdv_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.rd_valid |=> !q.rd_valid);
    // R7
    hit_keeps_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_OPEN && take && req_hit) |=> !q.ras_n);
    // R10
    busy_after_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> !req_ready);
endmodule

// File: rtl/pgdram_ctrl.sv
`timescale 1ns/1ps
module pgdram_ctrl #(
    parameter int A_W    = 10,
    parameter int DATA_W = 16,
    parameter int T_RAC  = 12,
    parameter int T_RC   = 22,
    parameter int T_CAC  = 3,
    parameter int T_PC   = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_we,
    input  logic [2*A_W-1:0]  req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic [A_W-1:0]    dram_addr,
    output logic              dram_ras_n,
    output logic              dram_cas_n,
    output logic              dram_we_n,
    output logic              dram_oe_n,
    output logic [DATA_W-1:0] dram_dq_o,
    output logic              dram_dq_oe,
    input  logic [DATA_W-1:0] dram_dq_i
);
    localparam int T_RCD = T_RAC - T_CAC;
    localparam int RC_W  = $clog2(T_RC + 1);
    localparam int PC_W  = $clog2(T_PC + 1);

    logic [A_W-1:0]  req_row, req_col, open_row;
    logic            req_hit, ras_fall, cas_fall;
    logic [RC_W-1:0] rc_cnt;
    logic [PC_W-1:0] pc_cnt;

    pgdram_addr_split #(.A_W(A_W)) u_split (
        .req_addr (req_addr),
        .open_row (open_row),
        .row      (req_row),
        .col      (req_col),
        .hit      (req_hit)
    );

    pgdram_span_cnt #(.LIMIT(T_RC), .W(RC_W)) u_row_span (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (ras_fall),
        .count   (rc_cnt)
    );

    pgdram_span_cnt #(.LIMIT(T_PC), .W(PC_W)) u_col_span (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (cas_fall),
        .count   (pc_cnt)
    );

    pgdram_seq #(
        .A_W(A_W), .DATA_W(DATA_W), .T_RCD(T_RCD), .T_CAC(T_CAC),
        .T_RC(T_RC), .T_PC(T_PC), .RC_W(RC_W), .PC_W(PC_W)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .req_we     (req_we),
        .req_row    (req_row),
        .req_col    (req_col),
        .req_hit    (req_hit),
        .req_wdata  (req_wdata),
        .rc_cnt     (rc_cnt),
        .pc_cnt     (pc_cnt),
        .ras_fall   (ras_fall),
        .cas_fall   (cas_fall),
        .open_row   (open_row),
        .rd_valid   (rd_valid),
        .rd_data    (rd_data),
        .dram_addr  (dram_addr),
        .dram_ras_n (dram_ras_n),
        .dram_cas_n (dram_cas_n),
        .dram_we_n  (dram_we_n),
        .dram_oe_n  (dram_oe_n),
        .dram_dq_o  (dram_dq_o),
        .dram_dq_oe (dram_dq_oe),
        .dram_dq_i  (dram_dq_i)
    );
endmodule

// File: tb/sim_pgdram_ctrl.sv
`timescale 1ns/1ps
module sim_pgdram_ctrl;
    localparam int A_W    = 4;
    localparam int DATA_W = 16;
    localparam int T_RAC  = 12;
    localparam int T_RC   = 22;
    localparam int T_CAC  = 3;
    localparam int T_PC   = 7;
    localparam int T_RCD  = T_RAC - T_CAC;
    localparam int NW     = 1 << (2 * A_W);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic              req_we = 1'b0;
    logic [2*A_W-1:0]  req_addr = '0;
    logic [DATA_W-1:0] req_wdata = '0;
    logic              rd_valid;
    logic [DATA_W-1:0] rd_data;
    logic [A_W-1:0]    dram_addr;
    logic              dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n;
    logic [DATA_W-1:0] dram_dq_o;
    logic              dram_dq_oe;
    logic [DATA_W-1:0] dram_dq_i = '0;

    always #2.5 clk = ~clk;

    pgdram_ctrl #(
        .A_W(A_W), .DATA_W(DATA_W), .T_RAC(T_RAC), .T_RC(T_RC),
        .T_CAC(T_CAC), .T_PC(T_PC)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data), .dram_addr(dram_addr),
        .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n),
        .dram_oe_n(dram_oe_n), .dram_dq_o(dram_dq_o), .dram_dq_oe(dram_dq_oe),
        .dram_dq_i(dram_dq_i)
    );

    int n_chk = 0;
    int n_err = 0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [DATA_W-1:0] seed_word(input int i);
        return DATA_W'(i * 40503) ^ DATA_W'(16'h5A5A);
    endfunction

    logic [DATA_W-1:0] dmem [NW];
    logic [DATA_W-1:0] ref_mem [NW];

    // expectations for the access in flight
    logic [A_W-1:0]    exp_row, exp_col, open_row_tb;
    logic              exp_we, exp_hit, have_open;
    logic [DATA_W-1:0] exp_wdata, exp_rdata;
    int                base_falls, base_rd;

    // model and monitor state
    int                cyc, m_ras, m_cas, ras_falls, rd_seen, last_ras, last_cas, bad5;
    bit                have_ras, have_cas;
    logic              p_ras_n, p_cas_n, p_we_n, p_dq_oe, p_rdv;
    logic [A_W-1:0]    m_row, m_col;

    initial begin
        for (int i = 0; i < NW; i++) begin
            dmem[i]    = seed_word(i);
            ref_mem[i] = seed_word(i);
        end
        cyc = 0; m_ras = 0; m_cas = 0; ras_falls = 0; rd_seen = 0;
        last_ras = 0; last_cas = 0; bad5 = 0; have_ras = 0; have_cas = 0;
        p_ras_n = 1; p_cas_n = 1; p_we_n = 1; p_dq_oe = 0; p_rdv = 0;
        m_row = '0; m_col = '0; have_open = 0; open_row_tb = '0;
        exp_row = '0; exp_col = '0; exp_we = 0; exp_hit = 0;
        exp_wdata = '0; exp_rdata = '0; base_falls = 0; base_rd = 0;
    end

    always @(negedge clk) begin
        if (rst_n) begin
            cyc++;
            // DRAM model: row/column latched on strobe fall, data valid after access times
            if (dram_ras_n) m_ras = 0; else m_ras++;
            if (dram_cas_n) m_cas = 0; else m_cas++;
            if (m_ras == 1) m_row = dram_addr;
            if (m_cas == 1) begin
                m_col = dram_addr;
                if (!dram_we_n) dmem[{m_row, m_col}] = dram_dq_o;
            end
            if (!dram_ras_n && !dram_cas_n && !dram_oe_n && dram_we_n)
                dram_dq_i = (m_cas >= T_CAC && m_ras >= T_RAC) ?
                            dmem[{m_row, m_col}] : ~dmem[{m_row, m_col}];
            else
                dram_dq_i = DATA_W'(16'hBAD0);
            if ((!dram_we_n && !dram_oe_n) || (dram_dq_oe && !dram_oe_n)) bad5++;

            // row strobe fall
            if (p_ras_n && !dram_ras_n) begin
                if (have_ras) chk(cyc - last_ras >= T_RC, "R8 row cycle spacing", cyc - last_ras, T_RC);
                chk(dram_addr == exp_row, "R2 row address", dram_addr, exp_row);
                ras_falls++;
                last_ras = cyc;
                have_ras = 1;
            end
            // column strobe fall
            if (p_cas_n && !dram_cas_n) begin
                chk(!dram_ras_n, "R9 column strobe inside open row", dram_ras_n, 0);
                chk(dram_addr == exp_col, "R2 column address", dram_addr, exp_col);
                if (have_cas) chk(cyc - last_cas >= T_PC, "R7 column cycle spacing", cyc - last_cas, T_PC);
                chk(ras_falls - base_falls == (exp_hit ? 0 : 1), exp_hit ? "R7 page hit keeps row" : "R8 miss reopens row",
                    ras_falls - base_falls, exp_hit ? 0 : 1);
                if (!exp_hit) chk(cyc - last_ras == T_RCD, "R3 row to column delay", cyc - last_ras, T_RCD);
                if (exp_we) begin
                    chk(!p_we_n && p_dq_oe && !dram_we_n && dram_dq_oe && dram_oe_n,
                        "R4 early write strobes", {p_we_n, p_dq_oe, dram_we_n, dram_dq_oe, dram_oe_n}, 5'b01011);
                    chk(dram_dq_o == exp_wdata, "R4 write data", dram_dq_o, exp_wdata);
                end else begin
                    chk(!dram_oe_n && dram_we_n && !dram_dq_oe, "R6 read strobes",
                        {dram_oe_n, dram_we_n, dram_dq_oe}, 3'b010);
                end
                last_cas = cyc;
                have_cas = 1;
            end
            if (rd_valid) begin
                chk(cyc - last_cas == T_CAC, "R3 read valid timing", cyc - last_cas, T_CAC);
                chk(rd_data == exp_rdata, "R3 read data", rd_data, exp_rdata);
                chk(!p_rdv, "R3 single cycle pulse", p_rdv, 0);
                rd_seen++;
            end
            p_ras_n = dram_ras_n; p_cas_n = dram_cas_n; p_we_n = dram_we_n;
            p_dq_oe = dram_dq_oe; p_rdv = rd_valid;
        end
    end

    task automatic do_req(input bit we, input logic [2*A_W-1:0] a, input logic [DATA_W-1:0] wd, input int gap);
        repeat (gap) @(negedge clk);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        exp_row   = a[2*A_W-1:A_W];
        exp_col   = a[A_W-1:0];
        exp_we    = we;
        exp_wdata = wd;
        exp_hit   = have_open && (exp_row == open_row_tb);
        open_row_tb = exp_row;
        have_open = 1;
        base_falls = ras_falls;
        base_rd   = rd_seen;
        if (we) ref_mem[a] = wd;
        else    exp_rdata = ref_mem[a];
        req_valid = 1'b1;
        req_we    = we;
        req_addr  = a;
        req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        chk(!req_ready, "R10 busy after accept", req_ready, 0);
        if (!we) while (rd_seen == base_rd) @(negedge clk);
    endtask

    function automatic logic [2*A_W-1:0] mk(input int r, input int c);
        return {A_W'(r), A_W'(c)};
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: run did not complete actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk(dram_ras_n && dram_cas_n && dram_we_n && dram_oe_n, "R1 strobes idle in reset",
            {dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n}, 4'hF);
        chk(!dram_dq_oe && !rd_valid, "R1 no drive, no valid in reset", {dram_dq_oe, rd_valid}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(dram_ras_n && dram_cas_n && dram_we_n && dram_oe_n && !dram_dq_oe && !rd_valid,
            "R1 idle after reset", {dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n, dram_dq_oe, rd_valid}, 6'b111100);
        chk(req_ready, "R1 ready after reset", req_ready, 1);

        // directed: first open, page hits, misses right after a short open
        do_req(1, mk(3, 5), 16'hA11A, 0);
        do_req(0, mk(3, 5), 16'h0, 0);
        do_req(1, mk(3, 9), 16'hB22B, 0);
        do_req(0, mk(3, 5), 16'h0, 0);
        do_req(0, mk(7, 1), 16'h0, 0);
        do_req(1, mk(7, 1), 16'hC33C, 0);
        do_req(0, mk(3, 9), 16'h0, 0);
        do_req(0, mk(7, 1), 16'h0, 0);
        do_req(1, mk(15, 15), 16'hFFFF, 0);
        do_req(0, mk(0, 0), 16'h0, 0);
        do_req(0, mk(15, 15), 16'h0, 3);

        // random traffic over a small set of rows
        for (int i = 0; i < 400; i++) begin
            do_req(1'($urandom % 2), mk(int'($urandom % 4), int'($urandom % 16)),
                   DATA_W'($urandom), int'($urandom % 3));
        end

        repeat (30) @(negedge clk);
        chk(bad5 == 0, "R5 no strobe conflict", bad5, 0);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule